// File: doc/BRIEF.md
# Wash Cycle Sequencer

This block steps a washer through a fixed chain of seven stages: prewash, main wash 1, main wash 2, rinse 1, rinse 2, graduated spin and spin. While a stage is active its own output line is held high, and it stays high for a number of clock cycles set by a parameter for that stage. A single down-counter times every stage. It is reloaded each time a new stage is entered.

A rising edge on the start button launches a cycle from idle. Two option inputs are captured at that edge and ignored after it. The first option decides whether the cycle opens with prewash or goes straight to main wash 1. The second option selects a reduced programme for delicate fabric. In the reduced programme main wash 2, rinse 2 and graduated spin are left out, so rinse 1 is followed directly by spin. When spin has run its time the sequencer drops back to idle and waits for the next press. A busy flag marks the whole run.

Top module: `wash_seq`

## Requirements
- R1: A synchronous active-high reset clears all seven stage lines and busy at the next clock edge, including in the middle of a cycle.
- R2: While idle, no stage line rises unless start_btn is sampled high at a clock edge where it was sampled low at the edge before.
- R3: At the launching edge, skip_prewash = 0 makes prewash (stage_q bit 0) the first stage, and skip_prewash = 1 makes main wash 1 (bit 1) the first stage. The first stage line is high after that same edge.
- R4: With light_load = 0 the stages follow the order bit 0 prewash, bit 1 main wash 1, bit 2 main wash 2, bit 3 rinse 1, bit 4 rinse 2, bit 5 graduated spin, bit 6 spin.
- R5: With light_load = 1 captured at launch, main wash 2, rinse 2 and graduated spin never become active, and rinse 1 is followed directly by spin.
- R6: Each stage line stays high for exactly its duration parameter in cycles (DUR_PRE, DUR_MW1, DUR_MW2, DUR_RN1, DUR_RN2, DUR_GSP, DUR_SPN, each at least 1). The next stage line rises in the cycle right after.
- R7: At most one stage line is high at any time, and busy is high exactly when one stage line is high.
- R8: Holding start_btn high does not start a second cycle, and edges on start_btn during a running cycle have no effect on it. A button held high through reset does not launch a cycle.
- R9: skip_prewash and light_load are sampled only at the launching edge. Changing them during a cycle does not alter the cycle.
- R10: After spin ends, all stage lines and busy are low in the next cycle, and the block waits for a new start edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_btn | input | 1 | Start button level; its rising edge launches a cycle |
| skip_prewash | input | 1 | 1 = begin at main wash 1, 0 = begin at prewash |
| light_load | input | 1 | 1 = reduced programme without main wash 2, rinse 2 and graduated spin |
| stage_q | output | 7 | One-hot active stage, bit 0 prewash through bit 6 spin |
| busy | output | 1 | High while a cycle is running |

## Verification
The first stage line and busy are registered at the clock edge that sees the start edge. Each later stage line rises at the edge where the previous stage's count runs out. The bench drives inputs on the falling edge and samples one falling edge later. It then walks the expected stage list cycle by cycle, checking each falling edge against the stage and a duration taken from the same parameters the design uses. The end of spin is checked at the falling edge after the last spin cycle, where everything must read low. The reset checks sample one falling edge after reset is raised.

// File: rtl/wash_pkg.sv
package wash_pkg;
  localparam int NUM_STAGES = 7;

  typedef enum logic [2:0] {
    ST_PRE = 3'd0,
    ST_MW1 = 3'd1,
    ST_MW2 = 3'd2,
    ST_RN1 = 3'd3,
    ST_RN2 = 3'd4,
    ST_GSP = 3'd5,
    ST_SPN = 3'd6
  } stage_e;
endpackage

// File: rtl/wash_edge.sv
module wash_edge (
  input  logic clk,
  input  logic rst,
  input  logic btn,
  output logic rise
);
  logic prev_q;

  // prev resets high so a button held through reset is not seen as a press
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= btn;
  end

  assign rise = btn & ~prev_q;
endmodule

// File: rtl/wash_next.sv
module wash_next
  import wash_pkg::*;
(
  input  stage_e cur,
  input  logic   reduced,
  output stage_e nxt
);
  always_comb begin
    unique case (cur)
      ST_PRE:  nxt = ST_MW1;
      ST_MW1:  nxt = reduced ? ST_RN1 : ST_MW2;
      ST_MW2:  nxt = ST_RN1;
      ST_RN1:  nxt = reduced ? ST_SPN : ST_RN2;
      ST_RN2:  nxt = ST_GSP;
      ST_GSP:  nxt = ST_SPN;
      default: nxt = ST_SPN;
    endcase
  end
endmodule

// File: rtl/wash_timer.sv
module wash_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/wash_seq.sv
module wash_seq
  import wash_pkg::*;
#(
  parameter int DUR_PRE = 600,
  parameter int DUR_MW1 = 1200,
  parameter int DUR_MW2 = 900,
  parameter int DUR_RN1 = 500,
  parameter int DUR_RN2 = 500,
  parameter int DUR_GSP = 300,
  parameter int DUR_SPN = 700
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_btn,
  input  logic                  skip_prewash,
  input  logic                  light_load,
  output logic [NUM_STAGES-1:0] stage_q,
  output logic                  busy
);
  localparam int DUR_MAX_A = (DUR_PRE > DUR_MW1) ? DUR_PRE : DUR_MW1;
  localparam int DUR_MAX_B = (DUR_MW2 > DUR_RN1) ? DUR_MW2 : DUR_RN1;
  localparam int DUR_MAX_C = (DUR_RN2 > DUR_GSP) ? DUR_RN2 : DUR_GSP;
  localparam int DUR_MAX_D = (DUR_MAX_A > DUR_MAX_B) ? DUR_MAX_A : DUR_MAX_B;
  localparam int DUR_MAX_E = (DUR_MAX_C > DUR_SPN) ? DUR_MAX_C : DUR_SPN;
  localparam int DUR_MAX   = (DUR_MAX_D > DUR_MAX_E) ? DUR_MAX_D : DUR_MAX_E;
  localparam int CW        = (DUR_MAX > 1) ? $clog2(DUR_MAX) : 1;

  function automatic logic [CW-1:0] reload_of(input stage_e s);
    int d;
    unique case (s)
      ST_PRE:  d = DUR_PRE;
      ST_MW1:  d = DUR_MW1;
      ST_MW2:  d = DUR_MW2;
      ST_RN1:  d = DUR_RN1;
      ST_RN2:  d = DUR_RN2;
      ST_GSP:  d = DUR_GSP;
      default: d = DUR_SPN;
    endcase
    return CW'(d - 1);
  endfunction

  logic   start_rise;
  logic   reduced_q;
  logic   tmr_done;
  logic   tmr_load;
  stage_e cur_q;
  stage_e nxt;
  stage_e first;
  stage_e target;

  wash_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .btn  (start_btn),
    .rise (start_rise)
  );

  wash_next u_next (
    .cur     (cur_q),
    .reduced (reduced_q),
    .nxt     (nxt)
  );

  assign first    = skip_prewash ? ST_MW1 : ST_PRE;
  assign target   = busy ? nxt : first;
  assign tmr_load = busy ? (tmr_done && cur_q != ST_SPN) : start_rise;

  wash_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (reload_of(target)),
    .expired  (tmr_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cur_q     <= ST_PRE;
      reduced_q <= 1'b0;
      stage_q   <= '0;
    end else if (!busy) begin
      if (start_rise) begin
        busy      <= 1'b1;
        reduced_q <= light_load;
        cur_q     <= first;
        stage_q   <= NUM_STAGES'(1) << first;
      end
    end else if (tmr_done) begin
      if (cur_q == ST_SPN) begin
        busy    <= 1'b0;
        stage_q <= '0;
      end else begin
        cur_q   <= nxt;
        stage_q <= NUM_STAGES'(1) << nxt;
      end
    end
  end
endmodule

// File: rtl/wash_seq_chk.sv
module wash_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       start_btn,
  input logic [6:0] stage_q,
  input logic       busy
);
  // R7
  onehot_stage_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stage_q));

  // R7
  busy_match_chk: assert property (@(posedge clk) disable iff (rst)
    busy == (stage_q != 7'd0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start_btn) |=> !busy);

  // R4
  pre_exit_chk: assert property (@(posedge clk) disable iff (rst)
    stage_q[0] |=> (stage_q[0] || stage_q[1]));

  // R5
  mw2_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stage_q[2]) |-> $past(stage_q[1]));

  // R10
  spin_exit_chk: assert property (@(posedge clk) disable iff (rst)
    stage_q[6] |=> (stage_q[6] || stage_q == 7'd0));
endmodule

bind wash_seq wash_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_btn (start_btn),
  .stage_q   (stage_q),
  .busy      (busy)
);

// File: tb/wash_seq_test.sv
module wash_seq_test;
  localparam int D0 = 2, D1 = 3, D2 = 1, D3 = 4, D4 = 2, D5 = 3, D6 = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_btn = 1'b0;
  logic       skip_prewash = 1'b0;
  logic       light_load = 1'b0;
  logic [6:0] stage_q;
  logic       busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  wash_seq #(
    .DUR_PRE(D0), .DUR_MW1(D1), .DUR_MW2(D2), .DUR_RN1(D3),
    .DUR_RN2(D4), .DUR_GSP(D5), .DUR_SPN(D6)
  ) uut (
    .clk(clk), .rst(rst), .start_btn(start_btn),
    .skip_prewash(skip_prewash), .light_load(light_load),
    .stage_q(stage_q), .busy(busy)
  );

  function automatic int dur(input int i);
    case (i)
      0: return D0; 1: return D1; 2: return D2; 3: return D3;
      4: return D4; 5: return D5; default: return D6;
    endcase
  endfunction

  // expected successor: reduced programme jumps 1->3 and 3->6
  function automatic int succ(input int i, input logic red);
    if (red && i == 1) return 3;
    if (red && i == 3) return 6;
    return i + 1;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", cycles);
      finish_run();
    end
  end

  // mode 0: pulse start; 1: hold start (R8); 2: toggle start during run (R8)
  task automatic run_cycle(input logic sel, input logic fab, input int mode);
    int idx;
    int n;
    @(negedge clk);
    start_btn = 1'b1; skip_prewash = sel; light_load = fab;
    @(negedge clk);
    if (mode != 1) start_btn = 1'b0;
    // R9: flip options after launch
    skip_prewash = ~sel; light_load = ~fab;
    idx = sel ? 1 : 0;
    n = 0;
    forever begin
      for (int k = 0; k < dur(idx); k++) begin
        // R3 R4 R5 R6
        chk(sel ? "R3/R6 stage" : "R4/R5/R6 stage", {1'b0, stage_q}, 8'(1) << idx);
        chk("R7 busy", {7'd0, busy}, 8'd1);
        if (mode == 2) start_btn = (idx != 6) ? n[0] : 1'b0;
        n++;
        @(negedge clk);
      end
      if (idx == 6) break;
      idx = succ(idx, fab);
    end
    // R10
    chk("R10 idle stage", {1'b0, stage_q}, 8'd0);
    chk("R10 idle busy", {7'd0, busy}, 8'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 no retrigger", {busy, stage_q}, 8'd0);
    end
    start_btn = 1'b0;
  endtask

  initial begin
    start_btn = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset", {busy, stage_q}, 8'd0);
    rst = 1'b0;
    // R8: held through reset, no launch
    repeat (3) begin
      @(negedge clk);
      chk("R8 held through reset", {busy, stage_q}, 8'd0);
    end
    start_btn = 1'b0;
    // R2: idle with start low
    repeat (4) begin
      @(negedge clk);
      chk("R2 idle", {busy, stage_q}, 8'd0);
    end
    for (int m = 0; m < 3; m++)
      for (int s = 0; s < 2; s++)
        for (int f = 0; f < 2; f++)
          run_cycle(s[0], f[0], m);
    // R1: reset in mid cycle
    @(negedge clk);
    start_btn = 1'b1; skip_prewash = 1'b0; light_load = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 busy before reset", {7'd0, busy}, 8'd1);
    rst = 1'b1; start_btn = 1'b0;
    @(negedge clk);
    chk("R1 mid-cycle reset", {busy, stage_q}, 8'd0);
    rst = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R2 idle after reset", {busy, stage_q}, 8'd0);
    end
    finish_run();
  end
endmodule